// File: doc/BRIEF.md
# PHY SuperSpeed Calibration Sequencer

This block tunes a USB 3.0 PHY once its host side is up. It does this with three override writes through an existing control-port writer. Nothing happens until a one-cycle trigger arrives. On a trigger the block captures the reference-clock select code and performs these writes in order:

1. The loss-of-signal detector override.
2. A higher transmit boost level.
3. A receiver-detect measurement time that depends on the reference clock frequency.

Each write is offered to the writer as a request. The request stays stable until the writer accepts it. The block then waits for the writer to report completion or an error before it moves on.

At the end the block pulses a done flag together with a 2-bit result code. A value of zero means all three writes completed. A value of 1, 2 or 3 names the write that failed. After a failure, no later write is issued.

Top module: `phy_cal_seq`

## Requirements
- R1: While reset is low, and in the first cycle after it, `wr_req_o` and `cal_done_o` are 0 and `cal_err_o` is 0.
- R2: The first write of a run has address 0x0015 and data 0xA409 (bias 5 in bits 15:13, enable at bit 10, level 9 in bits 4:0). It is requested two cycles after the trigger is sampled.
- R3: The second write has address 0x0012 and data 0xA000 (boost level 5 in bits 15:13).
- R4: The third write has address 0x1010 and data equal to a field shifted left by 4. The field depends on the select code captured at the trigger:
  - code 1 gives 0x20;
  - codes 2 and 3 give 0x04;
  - code 0 and codes 4 to 7 give 0x08.
- R5: Writes go out strictly in the order first, second, third. No request is raised while an accepted write is still awaiting completion.
- R6: Once raised, a request keeps its address and data unchanged until the cycle in which `wr_ack_i` is high. It drops in the cycle after acceptance.
- R7: If step n reports `wr_err_i`, the run stops and no later write is requested. `cal_done_o` pulses with `cal_err_o` = n. `wr_err_i` wins over a simultaneous `wr_done_i`. `cal_err_o` changes only with a done pulse and holds its value until the next one.
- R8: A fully successful run pulses `cal_done_o` for exactly one cycle with `cal_err_o` = 0. The pulse comes in the cycle after the third write's completion is sampled.
- R9: A trigger while a run is in progress is ignored. Changes of the select input after the trigger do not affect the third write.
- R10: Without a trigger the block issues no request and no done pulse.
- R11: A trigger sampled in the same cycle as the done pulse starts a new run. The done pulse and its code still report the run that finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_start_i | input | 1 | One-cycle calibration trigger |
| refclk_sel_i | input | 3 | Reference-clock select code (0: 24 MHz, 1: 50 MHz, 2: 20 MHz, 3: 19.2 MHz) |
| wr_req_o | output | 1 | Write request to the control-port writer |
| wr_addr_o | output | 16 | Control-port register address |
| wr_data_o | output | 16 | Control-port write data |
| wr_ack_i | input | 1 | Writer accepted the request |
| wr_done_i | input | 1 | Accepted write completed |
| wr_err_i | input | 1 | Accepted write failed (handshake timeout) |
| cal_done_o | output | 1 | One-cycle end-of-calibration pulse |
| cal_err_o | output | 2 | 0 on success, else number of the failing step |

## Verification
Two pairs of events can land in one cycle.

- **Done pulse and a new trigger.** The bench raises the trigger exactly in the cycle where the done pulse is visible. It then checks that the pulse and its code describe the old run, and that the new run issues its full write sequence from the newly captured select code.
- **Completion and error from the writer.** The bench asserts `wr_done_i` and `wr_err_i` together on a failing step. It expects the step-specific error code and no further request.

Around these, the bench sweeps every select code, every failing step, and several accept and completion latencies.

// File: rtl/phy_cal_pkg.sv
package phy_cal_pkg;

  typedef enum logic [1:0] {
    ST_LOS   = 2'd0,
    ST_BOOST = 2'd1,
    ST_RXDET = 2'd2
  } cal_step_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ISSUE = 2'd1,
    PH_WAIT  = 2'd2
  } cal_phase_e;

  localparam int unsigned WORD_W = 16;

  localparam logic [WORD_W-1:0] LOS_REG_ADDR   = 16'h0015;
  localparam logic [WORD_W-1:0] BOOST_REG_ADDR = 16'h0012;
  localparam logic [WORD_W-1:0] RXDET_REG_ADDR = 16'h1010;

  localparam int unsigned HI_FIELD_LSB  = 13;
  localparam int unsigned LOS_EN_BIT    = 10;
  localparam int unsigned RXDET_LSB     = 4;

  localparam logic [2:0] LOS_BIAS_VAL   = 3'd5;
  localparam logic [4:0] LOS_LEVEL_VAL  = 5'd9;
  localparam logic [2:0] BOOST_VAL      = 3'd5;

  localparam logic [6:0] RXDET_T_50M    = 7'h20;
  localparam logic [6:0] RXDET_T_20M    = 7'h04;
  localparam logic [6:0] RXDET_T_24M    = 7'h08;

  // Loss-of-signal override word: bias, enable, level.
  function automatic logic [WORD_W-1:0] los_override_word();
    logic [WORD_W-1:0] w;
    w = '0;
    w[HI_FIELD_LSB +: 3] = LOS_BIAS_VAL;
    w[LOS_EN_BIT]        = 1'b1;
    w[4:0]               = LOS_LEVEL_VAL;
    return w;
  endfunction

  // Transmit boost override word.
  function automatic logic [WORD_W-1:0] boost_override_word();
    logic [WORD_W-1:0] w;
    w = '0;
    w[HI_FIELD_LSB +: 3] = BOOST_VAL;
    return w;
  endfunction

  // Receive-detect time field for a reference clock code.
  function automatic logic [6:0] rxdet_time_field(input int unsigned code);
    logic [6:0] f;
    case (code)
      1:       f = RXDET_T_50M;
      2, 3:    f = RXDET_T_20M;
      default: f = RXDET_T_24M;
    endcase
    return f;
  endfunction

  function automatic logic [WORD_W-1:0] rxdet_word(input int unsigned code);
    logic [WORD_W-1:0] w;
    w = '0;
    w[RXDET_LSB +: 7] = rxdet_time_field(code);
    return w;
  endfunction

  // Failure code reported for a step: one above its index.
  function automatic logic [1:0] step_fail_code(input cal_step_e s);
    return 2'(s) + 2'd1;
  endfunction

endpackage

// File: rtl/cal_refclk_decode.sv
module cal_refclk_decode
  import phy_cal_pkg::*;
#(
  parameter int unsigned SEL_W = 3
) (
  input  logic [SEL_W-1:0]  sel_i,
  output logic [WORD_W-1:0] rxdet_word_o
);

  localparam int unsigned NCODES = 1 << SEL_W;

  logic [WORD_W-1:0] per_code [NCODES];

  // One precomputed word per select code; the captured code picks one.
  for (genvar c = 0; c < NCODES; c++) begin : g_code
    assign per_code[c] = rxdet_word(c);
  end

  assign rxdet_word_o = per_code[sel_i];

endmodule

// File: rtl/cal_step_rom.sv
module cal_step_rom
  import phy_cal_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  cal_step_e          step_i,
  input  logic [WORD_W-1:0]  rxdet_word_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [DATA_W-1:0]  data_o
);

  always_comb begin
    case (step_i)
      ST_LOS: begin
        addr_o = ADDR_W'(LOS_REG_ADDR);
        data_o = DATA_W'(los_override_word());
      end
      ST_BOOST: begin
        addr_o = ADDR_W'(BOOST_REG_ADDR);
        data_o = DATA_W'(boost_override_word());
      end
      default: begin
        addr_o = ADDR_W'(RXDET_REG_ADDR);
        data_o = DATA_W'(rxdet_word_i);
      end
    endcase
  end

endmodule

// File: rtl/cal_write_port.sv
module cal_write_port #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);

  logic              req_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  // Request register: loaded once per step, held until accepted.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (load_i) begin
      req_q  <= 1'b1;
      addr_q <= load_addr_i;
      data_q <= load_data_i;
    end else if (req_q && ack_i) begin
      req_q  <= 1'b0;
    end
  end

  assign req_o  = req_q;
  assign addr_o = addr_q;
  assign data_o = data_q;

endmodule

// File: rtl/cal_step_ctrl.sv
module cal_step_ctrl
  import phy_cal_pkg::*;
#(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             wr_done_i,
  input  logic             wr_err_i,
  output logic             issue_o,
  output cal_step_e        step_o,
  output logic [SEL_W-1:0] sel_q_o,
  output logic             done_o,
  output logic [1:0]       err_o,
  output logic             run_begin_o,
  output logic             step_ok_o,
  output logic             step_fail_o
);

  cal_phase_e       phase_q;
  cal_step_e        step_q;
  logic [SEL_W-1:0] sel_q;
  logic             done_q;
  logic [1:0]       err_q;

  assign run_begin_o = (phase_q == PH_IDLE) && start_i;
  assign step_fail_o = (phase_q == PH_WAIT) && wr_err_i;
  assign step_ok_o   = (phase_q == PH_WAIT) && wr_done_i && !wr_err_i;
  assign issue_o     = (phase_q == PH_ISSUE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      step_q  <= ST_LOS;
      sel_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 2'd0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            phase_q <= PH_ISSUE;
            step_q  <= ST_LOS;
            sel_q   <= sel_i;
          end
        end
        PH_ISSUE: phase_q <= PH_WAIT;
        PH_WAIT: begin
          if (wr_err_i) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
            err_q   <= step_fail_code(step_q);
          end else if (wr_done_i) begin
            if (step_q == ST_RXDET) begin
              phase_q <= PH_IDLE;
              done_q  <= 1'b1;
              err_q   <= 2'd0;
            end else begin
              step_q  <= cal_step_e'(step_q + 2'd1);
              phase_q <= PH_ISSUE;
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign step_o  = step_q;
  assign sel_q_o = sel_q;
  assign done_o  = done_q;
  assign err_o   = err_q;

endmodule

// File: rtl/phy_cal_seq.sv
module phy_cal_seq
  import phy_cal_pkg::*;
#(
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_start_i,
  input  logic [SEL_W-1:0]  refclk_sel_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              wr_ack_i,
  input  logic              wr_done_i,
  input  logic              wr_err_i,
  output logic              cal_done_o,
  output logic [1:0]        cal_err_o
);

  logic              issue;
  cal_step_e         step;
  logic [SEL_W-1:0]  sel_q;
  logic [WORD_W-1:0] rxdet_word;
  logic [ADDR_W-1:0] step_addr;
  logic [DATA_W-1:0] step_data;
  logic              run_begin;
  logic              step_ok;
  logic              step_fail;

  cal_step_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (cal_start_i),
    .sel_i       (refclk_sel_i),
    .wr_done_i   (wr_done_i),
    .wr_err_i    (wr_err_i),
    .issue_o     (issue),
    .step_o      (step),
    .sel_q_o     (sel_q),
    .done_o      (cal_done_o),
    .err_o       (cal_err_o),
    .run_begin_o (run_begin),
    .step_ok_o   (step_ok),
    .step_fail_o (step_fail)
  );

  cal_refclk_decode #(.SEL_W(SEL_W)) u_decode (
    .sel_i        (sel_q),
    .rxdet_word_o (rxdet_word)
  );

  cal_step_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rom (
    .step_i       (step),
    .rxdet_word_i (rxdet_word),
    .addr_o       (step_addr),
    .data_o       (step_data)
  );

  cal_write_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (issue),
    .load_addr_i (step_addr),
    .load_data_i (step_data),
    .ack_i       (wr_ack_i),
    .req_o       (wr_req_o),
    .addr_o      (wr_addr_o),
    .data_o      (wr_data_o)
  );

endmodule

// File: rtl/phy_cal_seq_props.sv
module phy_cal_seq_props #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_begin,
  input logic              step_fail,
  input logic              wr_req_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic              wr_ack_i,
  input logic              wr_done_i,
  input logic              wr_err_i,
  input logic              cal_done_o,
  input logic [1:0]        cal_err_o
);

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_o && !wr_ack_i) |=> (wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o)));

  assert_drop_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_req_o) |-> $past(wr_ack_i));

  assert_first_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_begin |-> ##2 (wr_req_o && wr_addr_o == ADDR_W'(16'h0015)
                       && wr_data_o == DATA_W'(16'hA409)));

  assert_done_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done_o |-> $past(wr_done_i || wr_err_i));

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done_o |=> !cal_done_o);

  assert_code_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cal_err_o) |-> cal_done_o);

  assert_fail_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step_fail |=> (cal_done_o && cal_err_o != 2'd0));

endmodule

bind phy_cal_seq phy_cal_seq_props #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_props (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_begin  (run_begin),
  .step_fail  (step_fail),
  .wr_req_o   (wr_req_o),
  .wr_addr_o  (wr_addr_o),
  .wr_data_o  (wr_data_o),
  .wr_ack_i   (wr_ack_i),
  .wr_done_i  (wr_done_i),
  .wr_err_i   (wr_err_i),
  .cal_done_o (cal_done_o),
  .cal_err_o  (cal_err_o)
);

// File: tb/phy_cal_seq_test.sv
module phy_cal_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cal_start_i = 1'b0;
  logic [2:0]  refclk_sel_i = 3'd0;
  logic        wr_ack_i = 1'b0;
  logic        wr_done_i = 1'b0;
  logic        wr_err_i = 1'b0;
  logic        wr_req_o;
  logic [15:0] wr_addr_o;
  logic [15:0] wr_data_o;
  logic        cal_done_o;
  logic [1:0]  cal_err_o;

  int checks = 0;
  int bad = 0;

  always #2 clk = ~clk;

  phy_cal_seq uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cal_start_i  (cal_start_i),
    .refclk_sel_i (refclk_sel_i),
    .wr_req_o     (wr_req_o),
    .wr_addr_o    (wr_addr_o),
    .wr_data_o    (wr_data_o),
    .wr_ack_i     (wr_ack_i),
    .wr_done_i    (wr_done_i),
    .wr_err_i     (wr_err_i),
    .cal_done_o   (cal_done_o),
    .cal_err_o    (cal_err_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [15:0] want_addr(input int n);
    if (n == 0) return 16'h0015;
    if (n == 1) return 16'h0012;
    return 16'h1010;
  endfunction

  function automatic logic [15:0] want_data(input int n, input int sel);
    int f;
    if (n == 0) return 16'(5 * 8192 + 1024 + 9);
    if (n == 1) return 16'(5 * 8192);
    if (sel == 1) f = 32;
    else if (sel == 2 || sel == 3) f = 4;
    else f = 8;
    return 16'(f * 16);
  endfunction

  task automatic run_case(input int sel, input int fstep, input int al, input int dl,
                          input bit skip_start, input bit chain, input int nsel);
    int nreq;
    string tag;
    logic [15:0] a0, d0;
    nreq = (fstep == 0) ? 3 : fstep;
    if (!skip_start) begin
      cal_start_i = 1'b1;
      refclk_sel_i = 3'(sel);
      tick();
      cal_start_i = 1'b0;
    end
    refclk_sel_i = 3'(sel ^ 5);                  // R9: late select change
    for (int n = 0; n < nreq; n++) begin
      int w;
      w = 0;
      while (!wr_req_o && w < 20) begin
        tick();
        w++;
      end
      chk(wr_req_o, "R5 request for next step", 32'(wr_req_o), 1);
      tag = (n == 0) ? "R2" : ((n == 1) ? "R3" : "R4 R9");
      chk(wr_addr_o == want_addr(n), {tag, " address"}, wr_addr_o, want_addr(n));
      chk(wr_data_o == want_data(n, sel), {tag, " data"}, wr_data_o, want_data(n, sel));
      a0 = wr_addr_o;
      d0 = wr_data_o;
      for (int k = 0; k < al; k++) begin
        tick();
        chk(wr_req_o && wr_addr_o == a0 && wr_data_o == d0, "R6 request held",
            {wr_addr_o, wr_data_o}, {a0, d0});
      end
      wr_ack_i = 1'b1;
      if (n == 1) cal_start_i = 1'b1;            // R9: retrigger mid-run
      tick();
      wr_ack_i = 1'b0;
      cal_start_i = 1'b0;
      chk(!wr_req_o, "R6 request dropped after accept", 32'(wr_req_o), 0);
      for (int k = 0; k < dl; k++) begin
        tick();
        chk(!wr_req_o, "R5 no request while pending", 32'(wr_req_o), 0);
      end
      if (n + 1 == fstep) begin
        wr_err_i = 1'b1;
        wr_done_i = (dl == 1);                   // R7: error beats done
      end else begin
        wr_done_i = 1'b1;
      end
      tick();
      wr_err_i = 1'b0;
      wr_done_i = 1'b0;
      if (n == nreq - 1) begin
        chk(cal_done_o, "R8 done pulse", 32'(cal_done_o), 1);
        chk(cal_err_o == 2'(fstep), (fstep != 0) ? "R7 failing step code" : "R8 success code",
            cal_err_o, fstep);
        if (chain) begin
          cal_start_i = 1'b1;                    // R11: trigger during done pulse
          refclk_sel_i = 3'(nsel);
          tick();
          cal_start_i = 1'b0;
          chk(!cal_done_o, "R11 done pulse one cycle", 32'(cal_done_o), 0);
          chk(cal_err_o == 2'(fstep), "R11 code of finished run", cal_err_o, fstep);
        end
      end else begin
        chk(!cal_done_o, "R5 no early done", 32'(cal_done_o), 0);
      end
    end
    if (!chain) begin
      for (int k = 0; k < 6; k++) begin
        tick();
        chk(!wr_req_o && !cal_done_o,
            (fstep != 0) ? "R7 no later writes" : "R9 retrigger ignored",
            {wr_req_o, cal_done_o}, 0);
      end
      chk(cal_err_o == 2'(fstep), "R7 code held", cal_err_o, fstep);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R5 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    tick();
    chk(!wr_req_o && !cal_done_o && cal_err_o == 0, "R1 reset outputs",
        {wr_req_o, cal_done_o, cal_err_o}, 0);
    tick();
    rst_n = 1'b1;
    tick();
    chk(!wr_req_o && !cal_done_o && cal_err_o == 0, "R1 after reset",
        {wr_req_o, cal_done_o, cal_err_o}, 0);
    for (int k = 0; k < 10; k++) begin
      tick();
      chk(!wr_req_o && !cal_done_o, "R10 idle without trigger", {wr_req_o, cal_done_o}, 0);
    end
    for (int sel = 0; sel < 8; sel++)
      for (int f = 0; f < 4; f++)
        for (int al = 0; al < 3; al++)
          for (int dl = 0; dl < 3; dl++)
            run_case(sel, f, al, dl, 1'b0, 1'b0, 0);
    // R11: back-to-back runs joined at the done pulse
    run_case(1, 0, 1, 1, 1'b0, 1'b1, 3);
    run_case(3, 0, 0, 2, 1'b1, 1'b1, 1);
    run_case(1, 3, 2, 0, 1'b1, 1'b0, 0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule